// File: doc/BRIEF.md
# Caption Row Horizontal Timing Generator

This block supplies the horizontal timing for a closed-caption overlay. A dot counter advances once per dot clock and covers 768 dots per scan line. It is re-aligned to the display by a horizontal flyback pulse, which may be active high or active low. The block learns the polarity from the level the pulse rests at between pulses.

From the dot count the block derives the character cell under the beam, the dot inside that cell, and two nested enables. The box enable covers 34 cells and frames the caption background. The text enable covers the 32 cells inside it, one cell in from each side. After reset both windows are centred on the line.

A narrow write port holds one register, the horizontal position. It moves both windows together in 4-dot steps. A new position takes effect only when the next line begins.

Top module: `caption_htiming`

## Requirements
- R1: After reset `dot_cnt` is 0, the stored position is 28 and the box window starts at dot 112. This centres the box on the line, and the text window then starts at dot 128.
- R2: Outside a resync, `dot_cnt` rises by one on every clock and wraps from 767 to 0.
- R3: `cell_idx` equals `dot_cnt` divided by 16 (range 0 to 47), and `cell_dot` equals `dot_cnt` modulo 16.
- R4: With the box start S in force, `box_en` is high exactly for dots S through S+543.
- R5: `text_en` is high exactly for dots S+16 through S+527, and it is never high while `box_en` is low.
- R6: A write with `wr_addr` equal to 0x02 stores the 8-bit `wr_data` as the position P. The box start that follows from it is the smaller of 4*P and 224, so the box never runs past dot 767.
- R7: A write to any address other than 0x02 leaves the position, and so both windows, unchanged.
- R8: A stored position takes effect on the clock at which `dot_cnt` returns to 0, whether by wrap or by resync. Until then the windows of the current line keep their old place.
- R9: A leading edge of the flyback pulse on `hs_in` makes `dot_cnt` read 0 after the third rising clock edge that follows the input change. Two of those edges are the synchronizer stages and one is the edge detector.
- R10: The idle level is the synchronized level of `hs_in` once it has stayed unchanged for 128 clocks; before that it is taken as low. Only a change away from the idle level resyncs the counter. The return to the idle level does not resync it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock, 768 cycles per line |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Horizontal flyback pulse, either polarity, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address; 0x02 selects the position register |
| wr_data | input | 8 | Register write data |
| dot_cnt | output | 10 | Dot position within the line, 0 to 767 |
| cell_idx | output | 6 | Character cell under the beam, 0 to 47 |
| cell_dot | output | 4 | Dot within the current cell, 0 to 15 |
| box_en | output | 1 | Caption box window, 34 cells wide |
| text_en | output | 1 | Caption text window, 32 cells wide |

## Verification
A change on `hs_in` shows up in `dot_cnt` after the third rising edge. A position write shows up in the windows only on the first clock at which the counter is back at 0. The cell fields and both enables follow the counter in the same cycle, with no added register. The bench drives inputs on the falling edge and advances its reference model on the rising edge through the same number of register stages. It compares every output at the next falling edge. The directed checks wait for the cycle in which a result is due: three edges after a pulse edge, or a named dot of the same line or of the following line after a write.

// File: rtl/caption_htiming_pkg.sv
package caption_htiming_pkg;

   // Limit a requested window start so that the whole window fits on the line.
   function automatic int clamp_start(input int raw, input int lim);
      return (raw > lim) ? lim : raw;
   endfunction

endpackage

// File: rtl/chg_hsync_edge.sv
module chg_hsync_edge #(
   parameter int IDLE_RUN    = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_in,
   output logic lead_edge
);
   localparam int RUN_W = $clog2(IDLE_RUN + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   hs_now;
   logic                   hs_prev;
   logic                   idle_lvl;
   logic [RUN_W-1:0]       run_q;
   logic                   run_full;

   // synchronizer depth chosen by parameter
   if (SYNC_STAGES == 2) begin : g_sync2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[0], hs_in};
      end
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], hs_in};
      end
   end

   assign hs_now   = sync_q[SYNC_STAGES-1];
   assign run_full = (run_q == RUN_W'(IDLE_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_prev  <= 1'b0;
         run_q    <= '0;
         idle_lvl <= 1'b0;
      end else begin
         hs_prev <= hs_now;
         if (hs_now != hs_prev)  run_q <= '0;
         else if (!run_full)     run_q <= run_q + 1'b1;
         if (hs_now == hs_prev && run_full) idle_lvl <= hs_now;
      end
   end

   assign lead_edge = (hs_now != hs_prev) && (hs_prev == idle_lvl);

   // R10: the learned idle level only moves once a steady run is complete
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_full |=> $stable(idle_lvl));

endmodule

// File: rtl/chg_dot_counter.sv
module chg_dot_counter #(
   parameter int DOTS  = 768,
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resync,
   output logic [CNT_W-1:0] dot_cnt,
   output logic             line_start
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DOTS - 1);

   logic at_last;

   assign at_last    = (dot_cnt == LAST);
   assign line_start = resync || at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                dot_cnt <= '0;
      else if (resync || at_last) dot_cnt <= '0;
      else                        dot_cnt <= dot_cnt + 1'b1;
   end

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!resync && dot_cnt != LAST) |=> dot_cnt == $past(dot_cnt) + 1'b1);

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_cnt == LAST) |=> dot_cnt == '0);

   p_resync_r9: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> dot_cnt == '0);

endmodule

// File: rtl/chg_hpos_reg.sv
module chg_hpos_reg
   import caption_htiming_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int POS_W     = 8,
   parameter int POS_ADDR  = 2,
   parameter int POS_STEP  = 4,
   parameter int RESET_POS = 28,
   parameter int MAX_START = 224,
   parameter int CNT_W     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [POS_W-1:0]  wr_data,
   input  logic              line_start,
   output logic [CNT_W-1:0]  box_start
);
   localparam logic [CNT_W-1:0] START_RST =
      CNT_W'(clamp_start(RESET_POS * POS_STEP, MAX_START));

   logic [POS_W-1:0] pos_q;
   logic             hit;
   logic [CNT_W-1:0] start_next;

   assign hit        = wr_en && (wr_addr == ADDR_W'(POS_ADDR));
   assign start_next = CNT_W'(clamp_start(int'(pos_q) * POS_STEP, MAX_START));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q     <= POS_W'(RESET_POS);
         box_start <= START_RST;
      end else begin
         if (hit)        pos_q     <= wr_data;
         if (line_start) box_start <= start_next;
      end
   end

   p_start_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(box_start));

   p_start_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      box_start <= CNT_W'(MAX_START));

endmodule

// File: rtl/chg_window.sv
module chg_window #(
   parameter int CNT_W = 10,
   parameter int INSET = 0,
   parameter int LEN   = 544
) (
   input  logic [CNT_W-1:0] dot_cnt,
   input  logic [CNT_W-1:0] base,
   output logic             win_en
);
   localparam int EXT = CNT_W + 1;

   logic [EXT-1:0] lo;
   logic [EXT-1:0] hi;
   logic [EXT-1:0] pos;

   assign lo     = EXT'(base) + EXT'(INSET);
   assign hi     = lo + EXT'(LEN);
   assign pos    = EXT'(dot_cnt);
   assign win_en = (pos >= lo) && (pos < hi);

endmodule

// File: rtl/caption_htiming.sv
module caption_htiming #(
   parameter  int DOTS        = 768,
   parameter  int CELL_DOTS   = 16,
   parameter  int BOX_CELLS   = 34,
   parameter  int TEXT_CELLS  = 32,
   parameter  int ADDR_W      = 8,
   parameter  int POS_W       = 8,
   parameter  int POS_ADDR    = 2,
   parameter  int POS_STEP    = 4,
   parameter  int IDLE_RUN    = 128,
   parameter  int SYNC_STAGES = 2,
   localparam int CNT_W       = $clog2(DOTS),
   localparam int CELL_W      = $clog2(CELL_DOTS),
   localparam int IDX_W       = CNT_W - CELL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [POS_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  dot_cnt,
   output logic [IDX_W-1:0]  cell_idx,
   output logic [CELL_W-1:0] cell_dot,
   output logic              box_en,
   output logic              text_en
);
   localparam int BOX_DOTS   = BOX_CELLS * CELL_DOTS;
   localparam int TEXT_DOTS  = TEXT_CELLS * CELL_DOTS;
   localparam int TEXT_INSET = ((BOX_CELLS - TEXT_CELLS) / 2) * CELL_DOTS;
   localparam int MAX_START  = DOTS - BOX_DOTS;
   localparam int RESET_POS  = (MAX_START / 2) / POS_STEP;

   // elaboration-time parameter checks
   if (CELL_DOTS != (1 << CELL_W)) begin : g_bad_cell
      $error("CELL_DOTS must be a power of two");
   end
   if (DOTS % CELL_DOTS != 0) begin : g_bad_line
      $error("DOTS must be a whole number of cells");
   end
   if (BOX_DOTS > DOTS) begin : g_bad_box
      $error("box window wider than the line");
   end
   if (TEXT_CELLS > BOX_CELLS || ((BOX_CELLS - TEXT_CELLS) % 2) != 0) begin : g_bad_text
      $error("text window must nest evenly inside the box");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are required");
   end
   if (POS_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("position address does not fit the address width");
   end

   logic             resync;
   logic             line_start;
   logic [CNT_W-1:0] box_start;
   logic [1:0]       win_vec;

   chg_hsync_edge #(
      .IDLE_RUN    (IDLE_RUN),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs_in     (hs_in),
      .lead_edge (resync)
   );

   chg_dot_counter #(
      .DOTS  (DOTS),
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .resync     (resync),
      .dot_cnt    (dot_cnt),
      .line_start (line_start)
   );

   chg_hpos_reg #(
      .ADDR_W    (ADDR_W),
      .POS_W     (POS_W),
      .POS_ADDR  (POS_ADDR),
      .POS_STEP  (POS_STEP),
      .RESET_POS (RESET_POS),
      .MAX_START (MAX_START),
      .CNT_W     (CNT_W)
   ) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .line_start (line_start),
      .box_start  (box_start)
   );

   // index 0: box window, index 1: text window
   for (genvar w = 0; w < 2; w++) begin : g_win
      localparam int INSET = (w == 1) ? TEXT_INSET : 0;
      localparam int LEN   = (w == 1) ? TEXT_DOTS  : BOX_DOTS;
      chg_window #(
         .CNT_W (CNT_W),
         .INSET (INSET),
         .LEN   (LEN)
      ) u_win (
         .dot_cnt (dot_cnt),
         .base    (box_start),
         .win_en  (win_vec[w])
      );
   end

   assign box_en   = win_vec[0];
   assign text_en  = win_vec[1];
   assign cell_idx = dot_cnt[CNT_W-1:CELL_W];
   assign cell_dot = dot_cnt[CELL_W-1:0];

   p_text_in_box_r5: assert property (@(posedge clk) disable iff (!rst_n)
      text_en |-> box_en);

endmodule

// File: tb/test_caption_htiming.sv
module test_caption_htiming;
   localparam int CLK_PERIOD = 10;
   localparam int DOTS  = 768;
   localparam int BOX   = 544;
   localparam int TEXT  = 512;
   localparam int INSET = 16;
   localparam int MAXS  = 224;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hs_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'd0;
   logic [7:0] wr_data = 8'd0;
   logic [9:0] dot_cnt;
   logic [5:0] cell_idx;
   logic [3:0] cell_dot;
   logic       box_en;
   logic       text_en;

   int checks = 0;
   int fails  = 0;
   bit chk_on = 1'b0;
   bit tb_idle = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   caption_htiming i_caption_htiming (
      .clk      (clk),
      .rst_n    (rst_n),
      .hs_in    (hs_in),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .dot_cnt  (dot_cnt),
      .cell_idx (cell_idx),
      .cell_dot (cell_dot),
      .box_en   (box_en),
      .text_en  (text_en)
   );

   function automatic int exp_start(input int p);
      return (p * 4 > MAXS) ? MAXS : p * 4;
   endfunction
   function automatic int exp_box(input int c, input int s);
      return (c >= s && c < s + BOX) ? 1 : 0;
   endfunction
   function automatic int exp_text(input int c, input int s);
      return (c >= s + INSET && c < s + INSET + TEXT) ? 1 : 0;
   endfunction

   // reference model: two sync stages, one edge stage, counter, position
   logic m_h1 = 1'b0, m_h2 = 1'b0, m_hp = 1'b0;
   int   m_cnt = 0, m_pos = 28, m_start = 112;
   logic m_edge;
   assign m_edge = (m_h2 != m_hp) && (m_hp == tb_idle);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_h1 <= 1'b0; m_h2 <= 1'b0; m_hp <= 1'b0;
         m_cnt <= 0; m_pos <= 28; m_start <= 112;
      end else begin
         m_h1 <= hs_in;
         m_h2 <= m_h1;
         m_hp <= m_h2;
         m_cnt <= (m_edge || m_cnt == DOTS - 1) ? 0 : m_cnt + 1;
         if (wr_en && wr_addr == 8'h02) m_pos <= int'(wr_data);
         if (m_edge || m_cnt == DOTS - 1) m_start <= exp_start(m_pos);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         chk("R2 R9 dot_cnt", int'(dot_cnt), m_cnt);
         chk("R3 cell_idx", int'(cell_idx), m_cnt / 16);
         chk("R3 cell_dot", int'(cell_dot), m_cnt % 16);
         chk("R4 R6 box_en", int'(box_en), exp_box(m_cnt, m_start));
         chk("R5 text_en", int'(text_en), exp_text(m_cnt, m_start));
      end
   end

   task automatic wait_dot(input int v);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (int'(dot_cnt) != v && n < 4 * DOTS);
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int r;
      void'($urandom(32'h5EED_0021));
      repeat (3) @(negedge clk);
      chk("R1 reset dot_cnt", int'(dot_cnt), 0);
      chk("R1 reset cell_idx", int'(cell_idx), 0);
      chk("R1 reset box_en", int'(box_en), 0);
      chk("R1 reset text_en", int'(text_en), 0);
      rst_n = 1'b1;
      chk_on = 1'b1;

      // R1: centred window edges
      wait_dot(111); chk("R1 box before 112", int'(box_en), 0);
      wait_dot(112); chk("R1 box at 112", int'(box_en), 1);
      wait_dot(127); chk("R1 text before 128", int'(text_en), 0);
      wait_dot(128); chk("R1 text at 128", int'(text_en), 1);
      wait_dot(640); chk("R5 text end 640", int'(text_en), 0);
      chk("R4 box still on at 640", int'(box_en), 1);
      wait_dot(656); chk("R4 box end 656", int'(box_en), 0);

      // R8: mid-line write keeps current line
      wait_dot(300); reg_write(8'h02, 8'd0);
      wait_dot(600); chk("R8 old position held mid-line", int'(box_en), 1);
      wait_dot(0);   chk("R8 new position at line start", int'(box_en), 1);
      wait_dot(600); chk("R8 new position next line", int'(box_en), 0);

      // R7: other addresses ignored
      wait_dot(10); reg_write(8'h03, 8'd100);
      reg_write(8'h82, 8'd100);
      wait_dot(0); wait_dot(0);
      wait_dot(100); chk("R7 foreign write ignored", int'(box_en), 1);
      wait_dot(20); chk("R7 text start unchanged", int'(text_en), 1);

      // R6: clamp at the right edge
      wait_dot(50); reg_write(8'h02, 8'd255);
      wait_dot(0);
      wait_dot(223); chk("R6 clamped start 224 before", int'(box_en), 0);
      wait_dot(224); chk("R6 clamped start 224", int'(box_en), 1);
      wait_dot(751); chk("R6 text last dot 751", int'(text_en), 1);
      wait_dot(752); chk("R6 text off at 752", int'(text_en), 0);
      wait_dot(767); chk("R6 box reaches 767", int'(box_en), 1);

      // R9 / R10: active-high resync and trailing edge
      wait_dot(400); hs_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 resync to zero", int'(dot_cnt), 0);
      repeat (20) @(negedge clk);
      hs_in = 1'b0; r = int'(dot_cnt);
      repeat (3) @(negedge clk);
      chk("R10 trailing edge ignored", int'(dot_cnt), (r + 3) % DOTS);

      // R10: switch to active-low pulses
      hs_in = 1'b1;
      repeat (300) @(negedge clk);
      tb_idle = 1'b1;
      wait_dot(300); hs_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 active-low leading edge", int'(dot_cnt), 0);
      repeat (10) @(negedge clk);
      hs_in = 1'b1; r = int'(dot_cnt);
      repeat (3) @(negedge clk);
      chk("R10 rising edge ignored when idle high", int'(dot_cnt), (r + 3) % DOTS);

      // random phase: writes and pulses of random timing
      for (int it = 0; it < 40; it++) begin
         int gap;
         int wid;
         if (it == 20) begin
            hs_in = tb_idle ? 1'b0 : 1'b1;
            repeat (300) @(negedge clk);
            tb_idle = ~tb_idle;
         end
         gap = 150 + int'($urandom % 800);
         for (int c = 0; c < gap; c++) begin
            if ($urandom % 50 == 0) begin
               wr_en = 1'b1;
               wr_addr = ($urandom % 3 == 0) ? 8'($urandom) : 8'h02;
               wr_data = 8'($urandom);
            end else begin
               wr_en = 1'b0;
            end
            @(negedge clk);
         end
         wr_en = 1'b0;
         wid = 1 + int'($urandom % 60);
         hs_in = ~tb_idle;
         repeat (wid) @(negedge clk);
         hs_in = tb_idle;
      end
      repeat (1000) @(negedge clk);

      chk_on = 1'b0;
      done = 1'b1;
      summary();
      $finish;
   end

endmodule